// File: doc/BRIEF.md
# Serial Flash Status and Protection Register

This block keeps the status byte of a serial flash device and decides which program and erase requests may go ahead. It receives an instruction-end strobe with the decoded opcode and the data byte that came with it, the level of the active-low write-protect pin, and live busy and sequential-program indications from the array sequencer. It also receives completion pulses from that sequencer. From these it keeps the write-enable latch, the two block-protect bits and the lock bit. It presents the assembled status byte and answers whether a given array address falls inside the protected region.

Status writes use a two-step sequence: an arm instruction must come directly before the status-write instruction, with nothing in between. The pin-based lock applies only while the protect pin is low and the lock bit is set. With the pin low and the lock bit clear, a single status write may raise the lock bit and change the protect level at once. The permit outputs combine the write-enable latch with the protect level, so the sequencer drops any program or erase request that falls in a guarded region.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte reads 0x0C: both protect bits set, lock bit, write-enable latch and mode bits clear, busy and sequential-program inputs low.
- R2: Status byte layout is bit0 busy (from `busy_in`), bit1 write-enable latch, bit2 protect-low, bit3 protect-high, bit6 sequential-program mode (from `seq_mode_in`), bit7 lock; bits 5 and 4 always read 0.
- R3: Opcode 0x06 at an instruction end sets the write-enable latch; opcode 0x04 clears it.
- R4: A pulse on `prog_done`, `erase_done` or `seq_top_hit` clears the write-enable latch, and wins over a same-cycle 0x06.
- R5: Opcode 0x01 (status write) takes effect only when the immediately preceding instruction end carried opcode 0x50 (arm); an arm followed by any other opcode is wasted.
- R6: An accepted status write loads only data bits 7, 3 and 2 into lock, protect-high and protect-low; all other status bits are unaffected.
- R7: With `wp_n` high at the ending instruction, an armed status write is accepted whatever the lock bit holds, including clearing it.
- R8: With `wp_n` low and the lock bit 1, an armed status write changes nothing.
- R9: With `wp_n` low and the lock bit 0, one armed status write can set the lock bit and change both protect bits together.
- R10: For the default 19-bit address, protect level 00 guards nothing, 01 guards 0x60000–0x7FFFF, 10 guards 0x40000–0x7FFFF, and 11 guards the whole array; `addr_protected` reports this for `qry_addr`.
- R11: `prog_grant` is high only when the latch is set and `qry_addr` is unguarded; `chip_grant` is high only when the latch is set and both protect bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_end | input | 1 | One-cycle strobe: an instruction finished (select rising edge) |
| op_code | input | 8 | Opcode of the finished instruction |
| op_data | input | 8 | Data byte carried by a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| busy_in | input | 1 | Internal program/erase in progress |
| seq_mode_in | input | 1 | Sequential-address program mode active |
| prog_done | input | 1 | Byte program completed |
| erase_done | input | 1 | Sector, block or chip erase completed |
| seq_top_hit | input | 1 | Sequential program reached the top address |
| qry_addr | input | 19 | Array address being checked |
| status_byte | output | 8 | Assembled status byte |
| addr_protected | output | 1 | `qry_addr` lies in the guarded region |
| prog_grant | output | 1 | Program or sector/block erase at `qry_addr` permitted |
| chip_grant | output | 1 | Whole-array erase permitted |

## Verification
The hardest situation to reach is a lock that has been raised and then must be shown to hold. The pin must be low, the lock bit already set, and an arm placed directly before the write. The stimulus table first raises the lock with the pin low and the lock bit clear, then sends a correctly armed write that tries to clear everything and confirms the status byte does not move. It then releases the pin and repeats the same armed write to prove that the pin alone lifts the lock. Wasted arms are produced by placing a write-enable between the arm and the status write.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_end,
  input  logic [7:0]    op_code,
  input  logic [7:0]    op_data,
  input  logic          wp_n,
  input  logic          busy_in,
  input  logic          seq_mode_in,
  input  logic          prog_done,
  input  logic          erase_done,
  input  logic          seq_top_hit,
  input  logic [AW-1:0] qry_addr,
  output logic [7:0]    status_byte,
  output logic          addr_protected,
  output logic          prog_grant,
  output logic          chip_grant
);

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_ARM  = 8'h50;
  localparam logic [7:0] OP_SWR  = 8'h01;

  logic       wel_q, bpl_q, armed_q;
  logic [1:0] bp_q;

  wire is_swr    = op_end && (op_code == OP_SWR);
  wire swr_ok    = is_swr && armed_q && (wp_n || !bpl_q);
  wire wel_clear = prog_done || erase_done || seq_top_hit ||
                   (op_end && (op_code == OP_WRDI));
  wire wel_set   = op_end && (op_code == OP_WREN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q   <= 1'b0;
      bpl_q   <= 1'b0;
      bp_q    <= 2'b11;
      armed_q <= 1'b0;
    end else begin
      if (op_end)
        armed_q <= (op_code == OP_ARM);
      if (wel_clear)
        wel_q <= 1'b0;
      else if (wel_set)
        wel_q <= 1'b1;
      if (swr_ok) begin
        bpl_q <= op_data[7];
        bp_q  <= op_data[3:2];
      end
    end
  end

  assign status_byte = {bpl_q, seq_mode_in, 2'b00, bp_q, wel_q, busy_in};

  wire [1:0] top2 = qry_addr[AW-1:AW-2];
  always_comb begin
    case (bp_q)
      2'b00:   addr_protected = 1'b0;
      2'b01:   addr_protected = (top2 == 2'b11);
      2'b10:   addr_protected = top2[1];
      default: addr_protected = 1'b1;
    endcase
  end

  assign prog_grant = wel_q && !addr_protected;
  assign chip_grant = wel_q && (bp_q == 2'b00);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[5:4] == 2'b00);

  assert_wren_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_end && op_code == OP_WREN && !prog_done && !erase_done && !seq_top_hit)
    |=> status_byte[1]);

  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done || erase_done || seq_top_hit) |=> !status_byte[1]);

  assert_unarmed_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_swr && !armed_q) |=> ($stable(status_byte[7]) && $stable(status_byte[3:2])));

  assert_locked_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_swr && !wp_n && status_byte[7]) |=> ($stable(status_byte[7]) && $stable(status_byte[3:2])));

  assert_grant_needs_wel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_grant || chip_grant) |-> status_byte[1]);

  assert_full_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[3:2] == 2'b11) |-> (addr_protected && !prog_grant));

endmodule

// File: tb/flash_status_guard_bench.sv
module flash_status_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_end = 1'b0;
  logic [7:0]  op_code = 8'h00;
  logic [7:0]  op_data = 8'h00;
  logic        wp_n = 1'b1;
  logic        busy_in = 1'b0;
  logic        seq_mode_in = 1'b0;
  logic        prog_done = 1'b0;
  logic        erase_done = 1'b0;
  logic        seq_top_hit = 1'b0;
  logic [18:0] qry_addr = '0;
  logic [7:0]  status_byte;
  logic        addr_protected, prog_grant, chip_grant;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_status_guard u_flash_status_guard (
    .clk(clk), .rst_n(rst_n), .op_end(op_end), .op_code(op_code),
    .op_data(op_data), .wp_n(wp_n), .busy_in(busy_in),
    .seq_mode_in(seq_mode_in), .prog_done(prog_done),
    .erase_done(erase_done), .seq_top_hit(seq_top_hit),
    .qry_addr(qry_addr), .status_byte(status_byte),
    .addr_protected(addr_protected), .prog_grant(prog_grant),
    .chip_grant(chip_grant));

  // {opcode, data, wp_n, expected status, requirement number}
  localparam logic [39:0] VEC [0:14] = '{
    {8'h01, 8'h00, 8'h01, 8'h0C, 8'd5},  // R5 status write with no arm
    {8'h50, 8'h00, 8'h01, 8'h0C, 8'd5},  // R5 arm
    {8'h06, 8'h00, 8'h01, 8'h0E, 8'd3},  // R3 write enable, arm wasted
    {8'h01, 8'h00, 8'h01, 8'h0E, 8'd5},  // R5 wasted arm leaves bits
    {8'h50, 8'h00, 8'h01, 8'h0E, 8'd5},  // R5 arm again
    {8'h01, 8'h73, 8'h01, 8'h02, 8'd6},  // R6 only bits 7,3,2 taken
    {8'h04, 8'h00, 8'h01, 8'h00, 8'd3},  // R3 write disable
    {8'h50, 8'h00, 8'h00, 8'h00, 8'd9},  // R9 arm, pin low
    {8'h01, 8'h88, 8'h00, 8'h88, 8'd9},  // R9 lock and level in one write
    {8'h50, 8'h00, 8'h00, 8'h88, 8'd8},  // R8 arm, pin low
    {8'h01, 8'h00, 8'h00, 8'h88, 8'd8},  // R8 refused while locked
    {8'h50, 8'h00, 8'h01, 8'h88, 8'd7},  // R7 arm, pin high
    {8'h01, 8'h04, 8'h01, 8'h04, 8'd7},  // R7 pin high lifts lock
    {8'h50, 8'h00, 8'h01, 8'h04, 8'd6},  // R6 arm
    {8'h01, 8'hFF, 8'h01, 8'h8C, 8'd6}   // R6 ignored bits stay clear
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic do_op(input logic [7:0] op, input logic [7:0] dat, input logic wp);
    @(negedge clk);
    op_code = op; op_data = dat; wp_n = wp; op_end = 1'b1;
    @(negedge clk);
    op_end = 1'b0;
  endtask

  task automatic set_level(input logic [7:0] dat);
    do_op(8'h50, 8'h00, 1'b1);
    do_op(8'h01, dat, 1'b1);
  endtask

  task automatic probe(input logic [18:0] a, input logic exp_p, input int req, input string what);
    qry_addr = a;
    #1;
    check(req, addr_protected, exp_p, what);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, status_byte, 8'h0C, "reset status R1");
    qry_addr = 19'h00000; #1;
    check(1, {prog_grant, chip_grant}, 2'b00, "no grants after reset R1");

    for (int i = 0; i < 15; i++) begin
      do_op(VEC[i][39:32], VEC[i][31:24], VEC[i][16]);
      check(int'(VEC[i][7:0]), status_byte, VEC[i][15:8], $sformatf("vector %0d", i));
    end

    // R2: live inputs land on bits 0 and 6, bits 5:4 stay zero
    busy_in = 1'b1; seq_mode_in = 1'b1; #1;
    check(2, status_byte, 8'hCD, "busy and mode bits R2");
    busy_in = 1'b0; seq_mode_in = 1'b0; #1;
    check(2, status_byte, 8'h8C, "bits drop back R2");

    // R10: each protect level
    set_level(8'h00);
    check(10, status_byte, 8'h00, "level 00 set R10");
    probe(19'h7FFFF, 1'b0, 10, "level 00 top R10");
    set_level(8'h04);
    probe(19'h5FFFF, 1'b0, 10, "level 01 below quarter R10");
    probe(19'h60000, 1'b1, 10, "level 01 quarter start R10");
    set_level(8'h08);
    probe(19'h3FFFF, 1'b0, 10, "level 10 below half R10");
    probe(19'h40000, 1'b1, 10, "level 10 half start R10");
    set_level(8'h0C);
    probe(19'h00000, 1'b1, 10, "level 11 bottom R10");

    // R11: grants
    set_level(8'h04);
    qry_addr = 19'h00100; #1;
    check(11, prog_grant, 1'b0, "no grant without latch R11");
    do_op(8'h06, 8'h00, 1'b1);
    qry_addr = 19'h00100; #1;
    check(11, prog_grant, 1'b1, "grant unguarded R11");
    qry_addr = 19'h70000; #1;
    check(11, prog_grant, 1'b0, "no grant guarded R11");
    check(11, chip_grant, 1'b0, "no chip erase at level 01 R11");
    set_level(8'h00);
    #1;
    check(11, chip_grant, 1'b1, "chip erase at level 00 R11");

    // R4: completion events
    @(negedge clk); prog_done = 1'b1; @(negedge clk); prog_done = 1'b0;
    check(4, status_byte[1], 1'b0, "program done clears R4");
    do_op(8'h06, 8'h00, 1'b1);
    @(negedge clk); erase_done = 1'b1; @(negedge clk); erase_done = 1'b0;
    check(4, status_byte[1], 1'b0, "erase done clears R4");
    do_op(8'h06, 8'h00, 1'b1);
    @(negedge clk); seq_top_hit = 1'b1; @(negedge clk); seq_top_hit = 1'b0;
    check(4, status_byte[1], 1'b0, "top reached clears R4");
    @(negedge clk);
    op_code = 8'h06; op_end = 1'b1; prog_done = 1'b1;
    @(negedge clk);
    op_end = 1'b0; prog_done = 1'b0;
    check(4, status_byte[1], 1'b0, "clear beats enable R4");

    finish_run();
  end
endmodule